// File: doc/BRIEF.md
# Two-Instruction Accumulator Processor

This block is a deliberately minimal processor built around a single accumulator, a program counter and one shared memory. The memory has 2^(W-1) words of W bits and holds program and data together; a word is read as an instruction or as a two's-complement number depending only on how it is reached. An instruction word is made of one opcode bit at the top and an address field X below it. There are just two operations. The first subtracts the word at X from the accumulator and puts the difference both in the accumulator and back into location X. The second loads X into the program counter.

Each instruction passes through three clocked phases: fetch, decode and execute. Because results are written back into the same memory that holds the program, code can modify itself. A jump to its own address is treated as a stop: the block enters a halted state and raises a flag, and the test environment can then end the run.

The memory is loaded through a dedicated write port that is only honoured while reset is held. The same address input, together with a read-data output, lets the environment read memory back during reset.

Top module: `acc2_cpu`

## Requirements
- R1: An instruction word has its opcode in bit W-1 (0 = subtract-and-store, 1 = jump) and the address X in bits W-2 down to 0.
- R2: Subtract-and-store sets the accumulator to (accumulator - mem[X]) modulo 2^W. Overflow wraps with no other effect.
- R3: Subtract-and-store writes the same W-bit result into mem[X].
- R4: Subtract-and-store advances the program counter by one modulo 2^(W-1), so that address 2^(W-1)-1 is followed by address 0.
- R5: A jump loads X into the program counter and leaves the accumulator and memory unchanged.
- R6: Every instruction takes exactly three cycles (fetch, decode, execute). Accumulator, program counter and memory change only at the clock edge that ends the execute cycle.
- R7: A synchronous active-high reset clears the accumulator and the program counter. Fetch starts at address 0 on the first cycle after reset is released.
- R8: A jump whose X equals its own address sets `halted`. From then on the flag stays high and the accumulator, program counter and memory stay frozen until reset.
- R9: While `rst` is high, `pre_we` writes `pre_data` into mem[`pre_addr`], and `mem_rdata` shows mem[`pre_addr`] one cycle after the address is presented. While `rst` is low, the preload port has no effect.
- R10: Instructions are fetched from the same memory that subtract-and-store writes, so a word written by one instruction is executed as written when it is reached later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; enables the preload port |
| pre_we | input | 1 | Preload write enable, honoured only during reset |
| pre_addr | input | W-1 | Preload and readback address |
| pre_data | input | W | Preload write data |
| mem_rdata | output | W | Registered memory read data |
| acc_out | output | W | Accumulator value |
| pc_out | output | W-1 | Program counter value |
| halted | output | 1 | High once a jump to its own address has executed |

## Verification
The embedded assertions check on every cycle that the program counter moves only at the end of execute, and that it then either steps by one after a subtract or takes the jump target. They also check that a jump leaves the accumulator alone and that the halted state is sticky and frozen. Arithmetic results, write-back into memory, wrap of the program counter from the top address to 0, self-modifying code and the inert preload port outside reset can only be shown by the bench's scenarios. For those, a behavioural model executes the same programs and compares the accumulator, program counter and halt flag every cycle, and memory is read back afterwards.

// File: rtl/acc2_pkg.sv
package acc2_pkg;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2,
        PH_HALT   = 2'd3
    } phase_e;

    localparam logic OP_SUBS = 1'b0;
    localparam logic OP_JUMP = 1'b1;

    function automatic logic is_jump(input logic opbit);
        return opbit == OP_JUMP;
    endfunction

endpackage

// File: rtl/acc2_mem.sv
module acc2_mem #(
    parameter int W  = 8,
    localparam int AW = W - 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] store [DEPTH];

    // read-before-write single port, one cycle latency
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end

endmodule

// File: rtl/acc2_ctrl.sv
module acc2_ctrl
    import acc2_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ir_op,
    input  logic   self_target,
    output phase_e phase
);

    phase_e phase_nx;

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_FETCH:  phase_nx = PH_DECODE;
            PH_DECODE: phase_nx = PH_EXEC;
            PH_EXEC:   phase_nx = (is_jump(ir_op) && self_target) ? PH_HALT : PH_FETCH;
            PH_HALT:   phase_nx = PH_HALT;
            default:   phase_nx = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_FETCH;
        end else begin
            phase <= phase_nx;
        end
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
        phase == PH_HALT |=> phase == PH_HALT); // R8

    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        phase == PH_FETCH |=> phase == PH_DECODE); // R6

endmodule

// File: rtl/acc2_dpath.sv
module acc2_dpath
    import acc2_pkg::*;
#(
    parameter int W  = 8,
    localparam int AW = W - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  phase_e        phase,
    input  logic [W-1:0]  rdata,
    output logic [W-1:0]  acc,
    output logic [AW-1:0] pc,
    output logic          ir_op,
    output logic          self_target,
    output logic [AW-1:0] run_addr,
    output logic          run_we,
    output logic [W-1:0]  run_wdata
);

    logic [W-1:0]  ir;
    logic [AW-1:0] ir_x;
    logic [W-1:0]  diff;
    logic          do_exec;

    assign ir_op       = ir[W-1];
    assign ir_x        = ir[AW-1:0];
    assign self_target = (ir_x == pc);
    assign diff        = acc - rdata;
    assign do_exec     = (phase == PH_EXEC);

    always_comb begin
        run_we    = 1'b0;
        run_wdata = diff;
        unique case (phase)
            PH_FETCH:  run_addr = pc;
            PH_DECODE: run_addr = rdata[AW-1:0];
            PH_EXEC: begin
                run_addr = ir_x;
                run_we   = !is_jump(ir_op);
            end
            default:   run_addr = pc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            pc  <= '0;
            ir  <= '0;
        end else begin
            if (phase == PH_DECODE) begin
                ir <= rdata;
            end
            if (do_exec) begin
                if (is_jump(ir_op)) begin
                    pc <= ir_x;
                end else begin
                    acc <= diff;
                    pc  <= pc + AW'(1);
                end
            end
        end
    end

    AST_PC_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
        !do_exec |=> $stable(pc)); // R6

    AST_SUBS_STEP: assert property (@(posedge clk) disable iff (rst)
        (do_exec && !ir_op) |=> pc == AW'($past(pc) + AW'(1))); // R4

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (do_exec && ir_op) |=> (pc == $past(ir_x)) && $stable(acc)); // R5

endmodule

// File: rtl/acc2_cpu.sv
module acc2_cpu
    import acc2_pkg::*;
#(
    parameter int W  = 8,
    localparam int AW = W - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [W-1:0]  pre_data,
    output logic [W-1:0]  mem_rdata,
    output logic [W-1:0]  acc_out,
    output logic [AW-1:0] pc_out,
    output logic          halted
);

    phase_e        phase;
    logic          ir_op;
    logic          self_target;
    logic [AW-1:0] run_addr;
    logic          run_we;
    logic [W-1:0]  run_wdata;
    logic [AW-1:0] m_addr;
    logic          m_we;
    logic [W-1:0]  m_wdata;

    // preload port owns the memory only while reset is held
    assign m_addr  = rst ? pre_addr : run_addr;
    assign m_we    = rst ? pre_we   : run_we;
    assign m_wdata = rst ? pre_data : run_wdata;
    assign halted  = (phase == PH_HALT);

    acc2_mem #(.W(W)) u_mem (
        .clk   (clk),
        .we    (m_we),
        .addr  (m_addr),
        .wdata (m_wdata),
        .rdata (mem_rdata)
    );

    acc2_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .ir_op       (ir_op),
        .self_target (self_target),
        .phase       (phase)
    );

    acc2_dpath #(.W(W)) u_dpath (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .rdata       (mem_rdata),
        .acc         (acc_out),
        .pc          (pc_out),
        .ir_op       (ir_op),
        .self_target (self_target),
        .run_addr    (run_addr),
        .run_we      (run_we),
        .run_wdata   (run_wdata)
    );

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(acc_out) && $stable(pc_out) && !m_we); // R8

endmodule

// File: tb/tb_acc2_cpu.sv
module tb_acc2_cpu;

    localparam int W  = 8;
    localparam int AW = 7;
    localparam int DEPTH = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [W-1:0]  pre_data = '0;
    logic [W-1:0]  mem_rdata;
    logic [W-1:0]  acc_out;
    logic [AW-1:0] pc_out;
    logic          halted;

    acc2_cpu #(.W(W)) dut (
        .clk(clk), .rst(rst), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .mem_rdata(mem_rdata), .acc_out(acc_out),
        .pc_out(pc_out), .halted(halted)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit cmp_on   = 1'b0;

    // behavioural reference model
    int m_mem [DEPTH];
    int m_acc = 0;
    int m_pc  = 0;
    int m_ph  = 0;
    bit m_halt = 1'b0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_acc = 0; m_pc = 0; m_ph = 0; m_halt = 1'b0;
        end else if (!m_halt) begin
            if (m_ph == 2) begin
                int word, x;
                word = m_mem[m_pc];
                x = word % DEPTH;
                if (word >= DEPTH) begin        // opcode bit set: jump (R1)
                    if (x == m_pc) m_halt = 1'b1;
                    m_pc = x;
                end else begin                  // subtract and store
                    m_acc = (m_acc - m_mem[x]) & 255;
                    m_mem[x] = m_acc;
                    m_pc = (m_pc + 1) % DEPTH;
                end
                m_ph = 0;
            end else begin
                m_ph++;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check(int'(acc_out) == m_acc, "R2 R6 accumulator", int'(acc_out), m_acc);
            check(int'(pc_out) == m_pc, "R4 R5 R6 program counter", int'(pc_out), m_pc);
            check(halted == m_halt, "R8 halted flag", int'(halted), int'(m_halt));
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic preload(input int a, input int d);
        pre_we = 1'b1; pre_addr = AW'(a); pre_data = W'(d);
        m_mem[a] = d & 255;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic peek(input int a, input string tag);
        pre_addr = AW'(a);
        @(negedge clk);
        check(int'(mem_rdata) == m_mem[a], tag, int'(mem_rdata), m_mem[a]);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) preload(i, 0);
    endtask

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        cmp_on = 1'b1;
        // reset state (R7)
        check(acc_out == '0 && pc_out == '0, "R7 reset state", int'(acc_out), 0);

        // program 1: arithmetic, skip by jump, wrap, halt
        clear_mem();
        preload(0, 8'h64);   // subtract 100
        preload(1, 8'h65);   // subtract 101
        preload(2, 8'h64);
        preload(3, 8'h85);   // jump 5
        preload(4, 8'h65);   // skipped
        preload(5, 8'h66);   // subtract 102
        preload(6, 8'h66);
        preload(7, 8'h67);
        preload(8, 8'h68);
        preload(9, 8'h69);
        preload(10, 8'h8A);  // jump to itself: halt
        preload(100, 5);
        preload(101, 3);
        preload(102, 8'h80);
        preload(103, 1);
        preload(104, 8'h7F);
        preload(105, 1);
        peek(100, "R9 preload readback");
        rst = 1'b0;
        check(halted == 1'b0, "R8 not halted at start", int'(halted), 0);
        while (!halted && cycles < 19000) @(negedge clk);
        check(m_acc == 8'h7F && int'(acc_out) == 8'h7F, "R2 wrap result", int'(acc_out), 8'h7F);
        check(int'(pc_out) == 10, "R8 halt address", int'(pc_out), 10);
        // sticky halt; preload port ignored outside reset (R9)
        pre_we = 1'b1; pre_addr = AW'(100); pre_data = 8'h55;
        repeat (6) @(negedge clk);
        pre_we = 1'b0;
        check(halted == 1'b1, "R8 halt sticky", int'(halted), 1);
        rst = 1'b1;
        @(negedge clk);
        for (int a = 100; a <= 105; a++) peek(a, "R3 R9 memory after run");
        peek(4, "R5 skipped word untouched");

        // program 2: self-modifying code and wrap of pc from 127 to 0
        clear_mem();
        preload(0, 8'hFF);   // jump 127
        preload(127, 8'h00); // subtract 0, rewrites word 0
        rst = 1'b0;
        repeat (60) @(negedge clk);
        // mid-run reset (R7)
        rst = 1'b1;
        @(negedge clk);
        check(acc_out == '0, "R7 mid-run reset acc", int'(acc_out), 0);
        check(pc_out == '0, "R7 mid-run reset pc", int'(pc_out), 0);
        peek(0, "R10 R3 rewritten word 0");
        peek(1, "R10 R3 rewritten word 1");
        peek(2, "R10 R3 rewritten word 2");
        peek(127, "R4 word at top address");

        // program 3: jump-only loop, accumulator untouched (R5)
        clear_mem();
        preload(0, 8'h82);   // jump 2
        preload(2, 8'h83);   // jump 3
        preload(3, 8'h83);   // halt
        rst = 1'b0;
        repeat (12) @(negedge clk);
        check(halted == 1'b1 && acc_out == '0, "R5 jumps leave acc", int'(acc_out), 0);
        check(int'(pc_out) == 3, "R5 R1 final pc", int'(pc_out), 3);

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule